// File: doc/BRIEF.md
# SIMD Arithmetic Fault Resolver

This block decides which architectural fault, if any, a 128-bit SIMD floating-point arithmetic instruction raises. Each instruction is offered as a single-cycle request. The request carries the relevant control-register bits, the CPU feature flags, the lock-prefix flag, the operating mode, the operand class and the low address bits. It also carries the privilege state and three precomputed address flags: a 16-bit-limit overflow, a non-canonical address, and a stack-segment reference.

Several fault conditions can hold at once: invalid opcode, device not available, general protection, stack fault, alignment check and SIMD numeric exception. The block reduces them to one prioritised fault. The alignment rule depends on the operand class. Packed 16-byte memory operands must be naturally aligned. Scalar 4-byte and 8-byte operands are tested only against their own size, and only when alignment checking applies. The result is registered. A valid strobe marks it one cycle after the request, and the fault vector holds until the next request.

Top module: `simd_fault_checker`

## Requirements
- R1: One clock after a cycle with `req_vld` high, `flt_vld` is high for exactly one cycle. `flt_vec` then keeps its value until the next request. Reset clears both outputs to zero.
- R2: `flt_vec` has at most one bit set, with these positions: bit 0 invalid opcode (UD), bit 1 device not available (NM), bit 2 general protection (GP), bit 3 stack fault (SS), bit 4 alignment check (AC), bit 5 SIMD numeric (XM).
- R3: UD is raised when `ctl_emul` is set, when `ctl_os_fxsave` is clear, or when `lock_pfx` is set.
- R4: UD is raised when the feature flag chosen by `feat_sel` is clear. The flags are `feat_vec[0]` for single-precision add, `feat_vec[1]` for double-precision scalar add and `feat_vec[2]` for packed add/subtract. A `feat_sel` value of 3 always gives UD.
- R5: NM is raised when `ctl_task_sw` is set.
- R6: A packed memory operand (`op_cls` = 1) whose `addr_lo[3:0]` is nonzero raises GP in every mode.
- R7: In real mode (`mode` = 0) or virtual-8086 mode (`mode` = 1), a memory operand with `lim_ovf` set raises GP. In the other modes `lim_ovf` has no effect.
- R8: In 64-bit mode (`mode` = 4), a memory operand with `non_canon` set raises SS when `stack_ref` is set and GP otherwise. SS wins over any other GP cause. Outside mode 4, `non_canon` has no effect. The other modes are protected (`mode` = 2) and compatibility (`mode` = 3).
- R9: A scalar memory operand raises AC when it is misaligned for its size and `ac_en` is set, and either `cpl` is 3 or the mode is virtual-8086. A 4-byte operand (`op_cls` = 2) is misaligned when `addr_lo[1:0]` is nonzero; an 8-byte operand (`op_cls` = 3) when `addr_lo[2:0]` is nonzero. AC is never raised in real mode.
- R10: An unmasked numeric exception (`num_exc`) raises XM when `ctl_os_simd_exc` is set and UD otherwise. It is reported only when no other fault applies.
- R11: A register operand (`op_cls` = 0) never raises GP, SS or AC, whatever the address, limit and canonical inputs say.
- R12: When several faults apply, one is reported in this order: UD, then NM, then SS/GP, then AC, then the numeric fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Request strobe, one per instruction |
| ctl_task_sw | input | 1 | Task-switched control bit |
| ctl_emul | input | 1 | Emulation control bit |
| ctl_os_fxsave | input | 1 | OS supports extended state save |
| ctl_os_simd_exc | input | 1 | OS handles unmasked SIMD exceptions |
| feat_vec | input | 3 | CPU feature flags per instruction group |
| feat_sel | input | 2 | Feature flag required by the instruction |
| lock_pfx | input | 1 | Lock prefix present |
| mode | input | 3 | Operating mode code |
| op_cls | input | 2 | Operand class code |
| addr_lo | input | 4 | Low bits of the effective address |
| ac_en | input | 1 | Alignment checking enabled |
| cpl | input | 2 | Current privilege level |
| lim_ovf | input | 1 | Operand crosses the 16-bit offset limit |
| non_canon | input | 1 | Address is non-canonical |
| stack_ref | input | 1 | Reference uses the stack segment |
| num_exc | input | 1 | Unmasked numeric exception pending |
| flt_vld | output | 1 | Result strobe, one cycle after request |
| flt_vec | output | 6 | One-hot fault vector |

## Verification
Every result is due exactly one rising edge after the request. The bench drives a request on a falling edge and lets the next rising edge capture it. It samples `flt_vld` and `flt_vec` on the following falling edge, while the strobe must be high. It drops the request at that point and samples again one full cycle later. At that second sample the strobe must be low and the vector must equal the value just seen, which covers the hold rule of R1.

// File: rtl/sfc_pkg.sv
// Shared encodings for the SIMD fault resolver.
// Assumes mode and operand-class codes arrive as raw bits on the top ports.
package sfc_pkg;

    typedef enum logic [2:0] {
        MD_REAL   = 3'd0,
        MD_V86    = 3'd1,
        MD_PROT   = 3'd2,
        MD_COMPAT = 3'd3,
        MD_LONG   = 3'd4
    } cpu_mode_e;

    typedef enum logic [1:0] {
        OP_REG    = 2'd0,
        OP_MEMVEC = 2'd1,
        OP_MEMS32 = 2'd2,
        OP_MEMS64 = 2'd3
    } op_cls_e;

    localparam int NUM_CLS = 4;
    localparam int FLT_W   = 6;
    localparam int FB_UD   = 0;
    localparam int FB_NM   = 1;
    localparam int FB_GP   = 2;
    localparam int FB_SS   = 3;
    localparam int FB_AC   = 4;
    localparam int FB_XM   = 5;

endpackage

// File: rtl/sfc_gate.sv
// Front gate checks: invalid-opcode causes from control bits, lock prefix
// and missing feature, plus the device-not-available condition.
// Assumes feat_sel values at or above NUM_FEAT denote no supported group.
module sfc_gate #(
    parameter int NUM_FEAT = 3,
    parameter int SEL_W    = 2
) (
    input  logic                ctl_task_sw,
    input  logic                ctl_emul,
    input  logic                ctl_os_fxsave,
    input  logic                lock_pfx,
    input  logic [NUM_FEAT-1:0] feat_vec,
    input  logic [SEL_W-1:0]    feat_sel,
    output logic                ud_pre,
    output logic                nm_pre
);

    logic feat_ok;

    // Pick the feature flag that matches the selected instruction group.
    always_comb begin
        feat_ok = 1'b0;
        for (int i = 0; i < NUM_FEAT; i++) begin
            if (feat_sel == SEL_W'(i)) feat_ok = feat_vec[i];
        end
    end

    // Combine the static invalid-opcode causes.
    always_comb begin
        ud_pre = ctl_emul | ~ctl_os_fxsave | lock_pfx | ~feat_ok;
        nm_pre = ctl_task_sw;
    end

endmodule

// File: rtl/sfc_mem.sv
// Memory-operand checks: natural alignment per operand class, the 16-bit
// limit in real and virtual-8086 modes, and the canonical-address rule in
// 64-bit mode. Assumes limit and canonical tests are done upstream.
module sfc_mem
    import sfc_pkg::*;
#(
    parameter int ADDR_LO_W = 4,
    parameter int VEC_BYTES = 16,
    parameter int S32_BYTES = 4,
    parameter int S64_BYTES = 8
) (
    input  logic [2:0]           mode,
    input  logic [1:0]           op_cls,
    input  logic [ADDR_LO_W-1:0] addr_lo,
    input  logic                 ac_en,
    input  logic [1:0]           cpl,
    input  logic                 lim_ovf,
    input  logic                 non_canon,
    input  logic                 stack_ref,
    output logic                 gp_flt,
    output logic                 ss_flt,
    output logic                 ac_flt
);

    localparam int CLS_BYTES [NUM_CLS] = '{1, VEC_BYTES, S32_BYTES, S64_BYTES};

    logic [NUM_CLS-1:0] misal;
    logic is_mem, is_real, is_v86, is_long, vec_mis, lim_hit, canon_hit;

    // One alignment comparator per memory class, sized from its byte count.
    assign misal[0] = 1'b0;
    for (genvar g = 1; g < NUM_CLS; g++) begin : g_align
        localparam logic [ADDR_LO_W-1:0] MSK = ADDR_LO_W'(CLS_BYTES[g] - 1);
        assign misal[g] = |(addr_lo & MSK);
    end

    // Decode the mode and operand class.
    always_comb begin
        is_mem  = (op_cls != OP_REG);
        is_real = (mode == MD_REAL);
        is_v86  = (mode == MD_V86);
        is_long = (mode == MD_LONG);
        vec_mis = (op_cls == OP_MEMVEC) & misal[OP_MEMVEC];
    end

    // Resolve the protection and alignment faults of a memory operand.
    always_comb begin
        lim_hit   = (is_real | is_v86) & lim_ovf;
        canon_hit = is_long & non_canon;
        ss_flt    = is_mem & canon_hit & stack_ref;
        gp_flt    = is_mem & ~ss_flt & (canon_hit | vec_mis | lim_hit);
        ac_flt    = is_mem & (op_cls != OP_MEMVEC) & misal[op_cls] & ac_en
                  & ~is_real & (is_v86 | (cpl == 2'd3));
    end

endmodule

// File: rtl/sfc_prio.sv
// Priority resolver: folds the candidate faults into one one-hot vector.
// Assumes its inputs come from the gate and memory checks of one request.
module sfc_prio
    import sfc_pkg::*;
(
    input  logic             ud_pre,
    input  logic             nm_pre,
    input  logic             gp_flt,
    input  logic             ss_flt,
    input  logic             ac_flt,
    input  logic             num_exc,
    input  logic             ctl_os_simd_exc,
    output logic [FLT_W-1:0] flt_nxt
);

    // Report the highest-ranked fault only.
    always_comb begin
        flt_nxt = '0;
        if (ud_pre)       flt_nxt[FB_UD] = 1'b1;
        else if (nm_pre)  flt_nxt[FB_NM] = 1'b1;
        else if (ss_flt)  flt_nxt[FB_SS] = 1'b1;
        else if (gp_flt)  flt_nxt[FB_GP] = 1'b1;
        else if (ac_flt)  flt_nxt[FB_AC] = 1'b1;
        else if (num_exc) begin
            if (ctl_os_simd_exc) flt_nxt[FB_XM] = 1'b1;
            else                 flt_nxt[FB_UD] = 1'b1;
        end
    end

endmodule

// File: rtl/simd_fault_checker.sv
// Top of the SIMD fault resolver. Evaluates one request per strobe and
// registers the single resulting fault with a one-cycle valid pulse.
// Assumes address-derived flags are already valid with the request.
module simd_fault_checker
    import sfc_pkg::*;
#(
    parameter int NUM_FEAT  = 3,
    parameter int ADDR_LO_W = 4,
    parameter int VEC_BYTES = 16,
    parameter int S32_BYTES = 4,
    parameter int S64_BYTES = 8,
    localparam int SEL_W    = $clog2(NUM_FEAT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_vld,
    input  logic                 ctl_task_sw,
    input  logic                 ctl_emul,
    input  logic                 ctl_os_fxsave,
    input  logic                 ctl_os_simd_exc,
    input  logic [NUM_FEAT-1:0]  feat_vec,
    input  logic [SEL_W-1:0]     feat_sel,
    input  logic                 lock_pfx,
    input  logic [2:0]           mode,
    input  logic [1:0]           op_cls,
    input  logic [ADDR_LO_W-1:0] addr_lo,
    input  logic                 ac_en,
    input  logic [1:0]           cpl,
    input  logic                 lim_ovf,
    input  logic                 non_canon,
    input  logic                 stack_ref,
    input  logic                 num_exc,
    output logic                 flt_vld,
    output logic [FLT_W-1:0]     flt_vec
);

    logic ud_pre, nm_pre, gp_flt, ss_flt, ac_flt;
    logic [FLT_W-1:0] flt_nxt;

    sfc_gate #(.NUM_FEAT(NUM_FEAT), .SEL_W(SEL_W)) u_gate (
        .ctl_task_sw   (ctl_task_sw),
        .ctl_emul      (ctl_emul),
        .ctl_os_fxsave (ctl_os_fxsave),
        .lock_pfx      (lock_pfx),
        .feat_vec      (feat_vec),
        .feat_sel      (feat_sel),
        .ud_pre        (ud_pre),
        .nm_pre        (nm_pre)
    );

    sfc_mem #(
        .ADDR_LO_W (ADDR_LO_W),
        .VEC_BYTES (VEC_BYTES),
        .S32_BYTES (S32_BYTES),
        .S64_BYTES (S64_BYTES)
    ) u_mem (
        .mode      (mode),
        .op_cls    (op_cls),
        .addr_lo   (addr_lo),
        .ac_en     (ac_en),
        .cpl       (cpl),
        .lim_ovf   (lim_ovf),
        .non_canon (non_canon),
        .stack_ref (stack_ref),
        .gp_flt    (gp_flt),
        .ss_flt    (ss_flt),
        .ac_flt    (ac_flt)
    );

    sfc_prio u_prio (
        .ud_pre          (ud_pre),
        .nm_pre          (nm_pre),
        .gp_flt          (gp_flt),
        .ss_flt          (ss_flt),
        .ac_flt          (ac_flt),
        .num_exc         (num_exc),
        .ctl_os_simd_exc (ctl_os_simd_exc),
        .flt_nxt         (flt_nxt)
    );

    // Capture the resolved fault on each request and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_vld <= 1'b0;
            flt_vec <= '0;
        end else begin
            flt_vld <= req_vld;
            if (req_vld) flt_vec <= flt_nxt;
        end
    end

endmodule

// File: rtl/sfc_chk.sv
// Checker for the SIMD fault resolver, bound to the top module.
// Relates request inputs to the registered outputs one cycle later.
module sfc_chk
    import sfc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic             lock_pfx,
    input logic [1:0]       op_cls,
    input logic             flt_vld,
    input logic [FLT_W-1:0] flt_vec
);

    AST_STROBE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> flt_vld);   // R1
    AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !flt_vld); // R1
    AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> $stable(flt_vec)); // R1
    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flt_vec));     // R2
    AST_LOCK_GIVES_UD: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && lock_pfx |=> flt_vec[FB_UD]); // R3
    AST_REG_NO_ADDR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && op_cls == OP_REG |=> !flt_vec[FB_GP] && !flt_vec[FB_SS] && !flt_vec[FB_AC]); // R11

endmodule

bind simd_fault_checker sfc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .lock_pfx (lock_pfx),
    .op_cls   (op_cls),
    .flt_vld  (flt_vld),
    .flt_vec  (flt_vec)
);

// File: tb/sim_simd_fault_checker.sv
// Directed bench for the SIMD fault resolver.
module sim_simd_fault_checker;

    localparam logic [5:0] F_NONE = 6'b000000;
    localparam logic [5:0] F_UD   = 6'b000001;
    localparam logic [5:0] F_NM   = 6'b000010;
    localparam logic [5:0] F_GP   = 6'b000100;
    localparam logic [5:0] F_SS   = 6'b001000;
    localparam logic [5:0] F_AC   = 6'b010000;
    localparam logic [5:0] F_XM   = 6'b100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_vld = 1'b0;
    logic ctl_task_sw, ctl_emul, ctl_os_fxsave, ctl_os_simd_exc;
    logic [2:0] feat_vec;
    logic [1:0] feat_sel;
    logic lock_pfx;
    logic [2:0] mode;
    logic [1:0] op_cls;
    logic [3:0] addr_lo;
    logic ac_en;
    logic [1:0] cpl;
    logic lim_ovf, non_canon, stack_ref, num_exc;
    logic flt_vld;
    logic [5:0] flt_vec;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    simd_fault_checker u0 (
        .clk (clk), .rst_n (rst_n), .req_vld (req_vld),
        .ctl_task_sw (ctl_task_sw), .ctl_emul (ctl_emul),
        .ctl_os_fxsave (ctl_os_fxsave), .ctl_os_simd_exc (ctl_os_simd_exc),
        .feat_vec (feat_vec), .feat_sel (feat_sel), .lock_pfx (lock_pfx),
        .mode (mode), .op_cls (op_cls), .addr_lo (addr_lo), .ac_en (ac_en),
        .cpl (cpl), .lim_ovf (lim_ovf), .non_canon (non_canon),
        .stack_ref (stack_ref), .num_exc (num_exc),
        .flt_vld (flt_vld), .flt_vec (flt_vec)
    );

    task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    // Legal protected-mode register operation with no fault cause.
    task automatic clean();
        ctl_task_sw = 0; ctl_emul = 0; ctl_os_fxsave = 1; ctl_os_simd_exc = 1;
        feat_vec = 3'b111; feat_sel = 2'd0; lock_pfx = 0;
        mode = 3'd2; op_cls = 2'd0; addr_lo = 4'h0; ac_en = 0; cpl = 2'd0;
        lim_ovf = 0; non_canon = 0; stack_ref = 0; num_exc = 0;
    endtask

    // Issue one request, check the strobe, the vector, then the hold cycle.
    task automatic run(input logic [5:0] exp, input string tag);
        logic [5:0] seen;
        @(negedge clk);
        req_vld = 1'b1;
        @(negedge clk);
        req_vld = 1'b0;
        chk({tag, " R1 strobe"}, {5'd0, flt_vld}, 6'd1);
        chk(tag, flt_vec, exp);
        seen = flt_vec;
        clean();
        @(negedge clk);
        chk({tag, " R1 strobe low"}, {5'd0, flt_vld}, 6'd0);
        chk({tag, " R1 hold"}, flt_vec, seen);
    endtask

    task automatic t_reset();
        clean();
        repeat (3) @(negedge clk);
        chk("R1 reset vld", {5'd0, flt_vld}, 6'd0);
        chk("R1 reset vec", flt_vec, F_NONE);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle vld", {5'd0, flt_vld}, 6'd0);
    endtask

    task automatic t_gate();
        clean(); run(F_NONE, "R2 clean");
        clean(); ctl_emul = 1; run(F_UD, "R3 emul");
        clean(); ctl_os_fxsave = 0; run(F_UD, "R3 fxsave");
        clean(); lock_pfx = 1; run(F_UD, "R3 lock");
    endtask

    task automatic t_feature();
        clean(); feat_sel = 2'd1; feat_vec = 3'b101; run(F_UD, "R4 dp missing");
        clean(); feat_sel = 2'd2; feat_vec = 3'b011; run(F_UD, "R4 addsub missing");
        clean(); feat_sel = 2'd0; feat_vec = 3'b110; run(F_UD, "R4 sp missing");
        clean(); feat_sel = 2'd3; run(F_UD, "R4 sel 3");
        clean(); feat_sel = 2'd2; feat_vec = 3'b100; run(F_NONE, "R4 addsub only");
    endtask

    task automatic t_nm();
        clean(); ctl_task_sw = 1; run(F_NM, "R5 task switched");
        clean(); ctl_task_sw = 1; lock_pfx = 1; run(F_UD, "R12 UD over NM");
        clean(); ctl_task_sw = 1; op_cls = 2'd1; addr_lo = 4'h8; run(F_NM, "R12 NM over GP");
    endtask

    task automatic t_packed();
        clean(); op_cls = 2'd1; addr_lo = 4'h8; run(F_GP, "R6 prot misaligned");
        clean(); op_cls = 2'd1; addr_lo = 4'h1; mode = 3'd0; run(F_GP, "R6 real misaligned");
        clean(); op_cls = 2'd1; addr_lo = 4'h0; run(F_NONE, "R6 aligned");
        clean(); op_cls = 2'd1; addr_lo = 4'h4; ac_en = 1; cpl = 2'd3; run(F_GP, "R12 GP over AC");
    endtask

    task automatic t_limit();
        clean(); mode = 3'd0; op_cls = 2'd2; lim_ovf = 1; run(F_GP, "R7 real limit");
        clean(); mode = 3'd1; op_cls = 2'd3; lim_ovf = 1; run(F_GP, "R7 v86 limit");
        clean(); mode = 3'd2; op_cls = 2'd2; lim_ovf = 1; run(F_NONE, "R7 prot ignores limit");
    endtask

    task automatic t_canon();
        clean(); mode = 3'd4; op_cls = 2'd3; non_canon = 1; run(F_GP, "R8 noncanon");
        clean(); mode = 3'd4; op_cls = 2'd3; non_canon = 1; stack_ref = 1; run(F_SS, "R8 stack");
        clean(); mode = 3'd4; op_cls = 2'd1; addr_lo = 4'h2; non_canon = 1; stack_ref = 1;
        run(F_SS, "R8 SS over GP");
        clean(); mode = 3'd3; op_cls = 2'd3; non_canon = 1; stack_ref = 1; run(F_NONE, "R8 compat ignores");
    endtask

    task automatic t_ac();
        clean(); op_cls = 2'd2; addr_lo = 4'h2; ac_en = 1; cpl = 2'd3; run(F_AC, "R9 s32 cpl3");
        clean(); op_cls = 2'd2; addr_lo = 4'h2; ac_en = 1; cpl = 2'd0; run(F_NONE, "R9 cpl0");
        clean(); mode = 3'd1; op_cls = 2'd2; addr_lo = 4'h1; ac_en = 1; run(F_AC, "R9 v86");
        clean(); mode = 3'd0; op_cls = 2'd2; addr_lo = 4'h1; ac_en = 1; cpl = 2'd3; run(F_NONE, "R9 real");
        clean(); op_cls = 2'd3; addr_lo = 4'h4; ac_en = 0; cpl = 2'd3; run(F_NONE, "R9 disabled");
        clean(); op_cls = 2'd3; addr_lo = 4'h4; ac_en = 1; cpl = 2'd3; run(F_AC, "R9 s64 misaligned");
        clean(); op_cls = 2'd3; addr_lo = 4'h8; ac_en = 1; cpl = 2'd3; run(F_NONE, "R9 s64 aligned");
        clean(); op_cls = 2'd2; addr_lo = 4'h4; ac_en = 1; cpl = 2'd3; run(F_NONE, "R9 s32 aligned");
    endtask

    task automatic t_numeric();
        clean(); num_exc = 1; run(F_XM, "R10 xm");
        clean(); num_exc = 1; ctl_os_simd_exc = 0; run(F_UD, "R10 ud");
        clean(); num_exc = 1; op_cls = 2'd2; addr_lo = 4'h3; ac_en = 1; cpl = 2'd3; run(F_AC, "R12 AC over XM");
        clean(); num_exc = 1; ctl_task_sw = 1; run(F_NM, "R12 NM over XM");
    endtask

    task automatic t_regop();
        clean(); mode = 3'd4; addr_lo = 4'h5; non_canon = 1; stack_ref = 1; ac_en = 1; cpl = 2'd3;
        run(F_NONE, "R11 reg in 64-bit");
        clean(); mode = 3'd0; lim_ovf = 1; addr_lo = 4'h7; run(F_NONE, "R11 reg in real");
    endtask

    initial begin
        t_reset();
        t_gate();
        t_feature();
        t_nm();
        t_packed();
        t_limit();
        t_canon();
        t_ac();
        t_numeric();
        t_regop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule